// File: doc/BRIEF.md
# Round-Constant Iota Unit

This block performs the iota step of the Keccak permutation on lane (0,0) and produces each round constant as it is needed. An 8-bit linear feedback shift register generates the constants, so the block needs no 24-entry constant table. A single iota command advances the register seven times. Each output bit chosen by those seven steps decides whether one fixed bit of the lane is inverted.

The register state is kept between commands. Successive iota commands therefore apply the round constants in order, round after round. A separate reseed command puts the register back to its starting value before a new permutation. A controller state machine has three states: `ST_IDLE`, `ST_ACK_IOTA` and `ST_ACK_SEED`. The transitions are *accept-iota* (`ST_IDLE` to `ST_ACK_IOTA`), *accept-seed* (`ST_IDLE` to `ST_ACK_SEED`), *reject* (`ST_IDLE` stays in `ST_IDLE` when start is low or the word is not a valid command) and *return* (either acknowledge state back to `ST_IDLE` after one cycle).

Commands arrive as 32-bit instruction words together with a start strobe and the current lane value. The updated lane is returned with a write enable and a done pulse. The register bank that holds the lanes sits outside this block.

Top module: `rc_iota_unit`

## Requirements
- R1: After reset, `lane_out` is zero and `lane_we` and `done` are low. The LFSR holds 0x01, so the first iota after reset on a zero lane yields 0x0000000000000001.
- R2: A word is accepted only when all of these hold:
  - bits [6:0] equal 7'b0001011;
  - bits [11:7] and [31:15] are zero;
  - bits [14:12] equal 3'b011 (iota) or 3'b100 (reseed).
  Any other word, or any word presented while start is low, has no effect: `done` stays low, `lane_out` is unchanged and the LFSR does not advance.
- R3: One LFSR step outputs bit 0 of the present state. It then shifts the state left by one, truncated to 8 bits. If bit 7 was set before the shift, the result is also XORed with 0x71.
- R4: An iota command performs seven steps, j = 0 to 6. When the output of step j is 1, bit 2^j−1 of the lane is inverted (bits 0, 1, 3, 7, 15, 31, 63). No other lane bit changes.
- R5: `done` is high for exactly one cycle, in the cycle after start is sampled with an accepted word. For an iota command, `lane_we` is high in that same cycle and `lane_out` already holds the result.
- R6: The LFSR state persists between commands. Successive iota commands on a zero lane yield the 24 round constants in order, beginning with 0x0000000000000001 and then 0x0000000000008082.
- R7: A reseed command sets the LFSR to 0x01. It pulses `done` with `lane_we` low and leaves `lane_out` unchanged.
- R8: A start strobe seen while the controller is in an acknowledge state is ignored. It neither advances the LFSR nor changes `lane_out`.
- R9: `lane_out` holds its value in every cycle where `lane_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, sampled in `ST_IDLE` |
| instr | input | 32 | Instruction word selecting iota or reseed |
| lane_in | input | 64 | Current value of lane (0,0) |
| lane_out | output | 64 | Lane (0,0) after the iota step |
| lane_we | output | 1 | Write enable for `lane_out` into the lane bank |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted LFSR state shows up as a wrong constant at the next iota. The error appears on `lane_out` one cycle after the strobe, and it recurs in every later round because the state carries forward. A wrong tap or a wrong shift typically agrees with the correct sequence for the first few constants and diverges later, which is why the bench walks all 24 constants. A controller stuck in an acknowledge state shows up as a `done` lasting more than one cycle, or as a missing `done` on the next command.

// File: rtl/rc_iota_pkg.sv
package rc_iota_pkg;

    localparam int LANE_W   = 64;
    localparam int LFSR_W   = 8;
    localparam int RC_STEPS = 7;
    localparam int INSTR_W  = 32;

    localparam logic [LFSR_W-1:0] RC_TAPS = 8'h71;
    localparam logic [LFSR_W-1:0] RC_SEED = 8'h01;

    localparam logic [6:0] OPC_CUSTOM = 7'b0001011;
    localparam logic [2:0] F3_IOTA    = 3'b011;
    localparam logic [2:0] F3_SEED    = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACK_IOTA = 2'd1,
        ST_ACK_SEED = 2'd2
    } rc_state_e;

    // Lane bits that an iota step is able to touch: 2^j - 1 for each step j.
    function automatic logic [LANE_W-1:0] flip_positions(input int steps);
        logic [LANE_W-1:0] m;
        m = '0;
        for (int j = 0; j < steps; j++) m[(1 << j) - 1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rc_lfsr_chain.sv
module rc_lfsr_chain #(
    parameter int                  W     = rc_iota_pkg::LFSR_W,
    parameter int                  STEPS = rc_iota_pkg::RC_STEPS,
    parameter logic [W-1:0]        TAPS  = rc_iota_pkg::RC_TAPS
) (
    input  logic [W-1:0]     state_i,
    output logic [STEPS-1:0] bits_o,
    output logic [W-1:0]     state_o
);
    logic [W-1:0] link [0:STEPS];

    assign link[0] = state_i;

    for (genvar j = 0; j < STEPS; j++) begin : g_step
        logic [W-1:0] shifted;
        assign shifted     = {link[j][W-2:0], 1'b0};
        assign bits_o[j]   = link[j][0];
        assign link[j+1]   = link[j][W-1] ? (shifted ^ TAPS) : shifted;
    end

    assign state_o = link[STEPS];
endmodule

// File: rtl/rc_flip_map.sv
module rc_flip_map #(
    parameter int LANE_W = rc_iota_pkg::LANE_W,
    parameter int STEPS  = rc_iota_pkg::RC_STEPS
) (
    input  logic [STEPS-1:0]  bits_i,
    output logic [LANE_W-1:0] mask_o
);
    always_comb begin
        mask_o = '0;
        for (int j = 0; j < STEPS; j++) mask_o[(1 << j) - 1] = bits_i[j];
    end
endmodule

// File: rtl/rc_ctrl_fsm.sv
module rc_ctrl_fsm
    import rc_iota_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      cmd_iota,
    input  logic      cmd_seed,
    output logic      fire_iota,
    output logic      fire_seed,
    output logic      done,
    output logic      we,
    output rc_state_e state
);
    rc_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (start && cmd_iota)      state_d = ST_ACK_IOTA;
                else if (start && cmd_seed) state_d = ST_ACK_SEED;
            end
            ST_ACK_IOTA: state_d = ST_IDLE;
            ST_ACK_SEED: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        fire_iota = 1'b0;
        fire_seed = 1'b0;
        done      = 1'b0;
        we        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                fire_iota = start && cmd_iota;
                fire_seed = start && cmd_seed && !cmd_iota;
            end
            ST_ACK_IOTA: begin
                done = 1'b1;
                we   = 1'b1;
            end
            ST_ACK_SEED: done = 1'b1;
            default: ;
        endcase
    end

    // R8
    ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/rc_iota_unit.sv
module rc_iota_unit
    import rc_iota_pkg::*;
#(
    parameter int                 LANE_BITS = LANE_W,
    parameter int                 STATE_W   = LFSR_W,
    parameter int                 STEPS     = RC_STEPS,
    parameter logic [STATE_W-1:0] TAPS      = RC_TAPS,
    parameter logic [STATE_W-1:0] SEED      = RC_SEED
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [LANE_BITS-1:0] lane_in,
    output logic [LANE_BITS-1:0] lane_out,
    output logic                 lane_we,
    output logic                 done
);
    localparam logic [LANE_BITS-1:0] POS_MASK = LANE_BITS'(flip_positions(STEPS));

    logic                 shape_ok, cmd_iota, cmd_seed;
    logic                 fire_iota, fire_seed;
    logic [STATE_W-1:0]   lfsr_q, lfsr_adv;
    logic [STEPS-1:0]     rc_bits;
    logic [LANE_BITS-1:0] flip_mask;
    rc_state_e            state;

    assign shape_ok = (instr[6:0] == OPC_CUSTOM) && (instr[11:7] == '0)
                      && (instr[INSTR_W-1:15] == '0);
    assign cmd_iota = shape_ok && (instr[14:12] == F3_IOTA);
    assign cmd_seed = shape_ok && (instr[14:12] == F3_SEED);

    rc_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_iota  (cmd_iota),
        .cmd_seed  (cmd_seed),
        .fire_iota (fire_iota),
        .fire_seed (fire_seed),
        .done      (done),
        .we        (lane_we),
        .state     (state)
    );

    rc_lfsr_chain #(.W(STATE_W), .STEPS(STEPS), .TAPS(TAPS)) u_chain (
        .state_i (lfsr_q),
        .bits_o  (rc_bits),
        .state_o (lfsr_adv)
    );

    rc_flip_map #(.LANE_W(LANE_BITS), .STEPS(STEPS)) u_map (
        .bits_i (rc_bits),
        .mask_o (flip_mask)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q   <= SEED;
            lane_out <= '0;
        end else begin
            if (fire_iota) begin
                lfsr_q   <= lfsr_adv;
                lane_out <= lane_in ^ flip_mask;
            end else if (fire_seed) begin
                lfsr_q   <= SEED;
            end
        end
    end

    // R5
    we_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we |-> done);

    // R9
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_we |-> $stable(lane_out));

    // R4
    flip_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we |-> (((lane_out ^ $past(lane_in)) & ~POS_MASK) == '0));

    // R7
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_SEED) |-> (lfsr_q == SEED));

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: tb/rc_iota_unit_bench.sv
module rc_iota_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] W_IOTA = 32'h0000_300B;
    localparam logic [31:0] W_SEED = 32'h0000_400B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] lane_in = '0;
    logic [63:0] lane_out;
    logic        lane_we, done;

    int checks = 0;
    int fails  = 0;
    logic [7:0]  m_lfsr;
    logic [63:0] m_lane;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc_iota_unit u_rc_iota_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .lane_in(lane_in), .lane_out(lane_out), .lane_we(lane_we), .done(done)
    );

    // R3 R4 model: seven steps, output j flips bit 2^j-1.
    function automatic logic [63:0] model_rc(inout logic [7:0] s);
        logic [63:0] m = '0;
        for (int j = 0; j < 7; j++) begin
            if (s[0]) m[(1 << j) - 1] = 1'b1;
            s = s[7] ? ((s << 1) ^ 8'h71) : (s << 1);
        end
        return m;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one command for one cycle, then sample the response cycle.
    task automatic issue(input logic [31:0] w, input logic [63:0] lane, input string req);
        logic legal_iota = (w == W_IOTA);
        logic legal_seed = (w == W_SEED);
        @(negedge clk);
        start = 1'b1; instr = w; lane_in = lane;
        @(negedge clk);
        start = 1'b0;
        if (legal_iota) begin
            m_lane = lane ^ model_rc(m_lfsr);
        end else if (legal_seed) begin
            m_lfsr = 8'h01;
        end
        check({req, " done"}, {63'b0, done}, {63'b0, legal_iota | legal_seed});
        check({req, " we"}, {63'b0, lane_we}, {63'b0, legal_iota});
        check({req, " lane"}, lane_out, m_lane);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        m_lfsr = 8'h01;
        m_lane = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 lane", lane_out, 64'h0);
        check("R1 done", {63'b0, done}, 64'h0);
        check("R1 we", {63'b0, lane_we}, 64'h0);

        // R1 R6 first two constants, literal values
        issue(W_IOTA, 64'h0, "R1");
        check("R6 rc0", lane_out, 64'h0000_0000_0000_0001);
        issue(W_IOTA, 64'h0, "R6");
        check("R6 rc1", lane_out, 64'h0000_0000_0000_8082);
        // R6 remaining constants of the 24-round schedule
        for (int r = 2; r < 24; r++) issue(W_IOTA, 64'h0, "R6 seq");
        check("R6 last", lane_out, 64'h8000_0000_8000_8008);

        // R7 reseed restores the first constant, lane unchanged
        issue(W_SEED, $urandom, "R7");
        issue(W_IOTA, 64'h0, "R7 after");
        check("R7 rc0", lane_out, 64'h1);

        // R2 illegal words: no done, no LFSR advance
        issue(32'h0000_308B, 64'h5, "R2 rd");
        issue(32'h0000_300A, 64'h5, "R2 opc");
        issue(32'h0000_000B, 64'h5, "R2 f3");
        issue(32'h0010_300B, 64'h5, "R2 hi");
        issue(W_IOTA, 64'h0, "R2 next");
        check("R2 rc1", lane_out, 64'h8082);

        // R8 start held through the acknowledge cycle
        @(negedge clk);
        start = 1'b1; instr = W_IOTA; lane_in = 64'hFFFF_FFFF_FFFF_FFFF;
        m_lane = lane_in ^ model_rc(m_lfsr);
        @(negedge clk);
        lane_in = 64'h0;
        check("R5 done", {63'b0, done}, 64'h1);
        check("R5 lane", lane_out, m_lane);
        @(negedge clk);
        start = 1'b0;
        check("R8 done", {63'b0, done}, 64'h0);
        check("R8 lane", lane_out, m_lane);
        issue(W_IOTA, 64'h0, "R8 next");

        // R9 idle cycles hold the lane
        lane_in = 64'hDEAD_BEEF_0123_4567;
        repeat (3) @(negedge clk);
        check("R9 hold", lane_out, m_lane);

        // Random mix of legal, corrupted and reseed commands
        for (int k = 0; k < 300; k++) begin
            logic [31:0] w;
            logic [63:0] ln;
            int sel;
            sel = int'($urandom_range(0, 9));
            ln = {$urandom, $urandom};
            if (sel < 6)      w = W_IOTA;
            else if (sel < 7) w = W_SEED;
            else begin
                w = (sel == 7) ? W_IOTA : W_SEED;
                w[$urandom_range(0, 31)] ^= 1'b1;
            end
            issue(w, ln, "R4 rand");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule